// File: doc/BRIEF.md
# SPI Sequential Array Read Front End

This block is the slave side of a serial memory read path. A host selects it by pulling chip select low, sends an 8-bit command and a 16-bit start address on the serial input, and then keeps clocking to pull stored bytes out of the serial output. The block fetches each byte from a memory through a synchronous read port and streams it out most significant bit first. After every byte it moves to the next address. It wraps from the top of the array back to zero, so a host can read any run of bytes in one frame.

The SPI lines are oversampled by a faster system clock. SCK, chip select and SI pass through a synchronizer. Edges of SCK are detected in the system clock domain, so the whole block is a single clock domain. The serial output comes with a separate enable, which is low whenever the block must leave the line floating. Only the read command (0x03) is acted on. Any other command makes the block ignore the rest of the frame.

Top module: `spi_rd_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `so_oe_o` and `mem_rd_o` are 0.
- R2: `so_oe_o` stays 0 for the whole command phase and the whole address phase of a frame.
- R3: SI is sampled on rising SCK, MSB first. The first 8 bits form the command. When the command equals 0x03, the next 16 bits form the start address. Only the low `ADDR_W` bits (12 by default) select the memory location, and the upper address bits have no effect on the bytes returned.
- R4: In the data phase, SO changes only on falling SCK. Each byte is presented MSB first and holds stable across the following rising edge, with `so_oe_o` at 1. The first data bit is driven on the falling edge that follows the last address bit.
- R5: After each complete data byte, the address advances by one, and bytes keep streaming for as long as SCK keeps toggling.
- R6: After address 2^ADDR_W−1, the address wraps to 0.
- R7: A command other than 0x03 causes no memory read and keeps `so_oe_o` at 0 until chip select rises, even if later SI bits look like a read command.
- R8: Chip select rising ends the frame in any phase. `so_oe_o` returns to 0, and the next frame starts over with a fresh command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x faster than SCK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock, mode 0 |
| cs_ni | input | 1 | SPI chip select, active low |
| si_i | input | 1 | Serial data from host |
| so_o | output | 1 | Serial data to host |
| so_oe_o | output | 1 | Output enable for the SO pad; 0 means high impedance |
| mem_rd_o | output | 1 | One-cycle read strobe to memory |
| mem_addr_o | output | ADDR_W | Memory read address, valid with `mem_rd_o` |
| mem_rdata_i | input | 8 | Read data, valid the cycle after `mem_rd_o` |

## Verification
The bench reads across the top of the array. A design that saturates or ignores the carry would repeat the top byte or jump to a wrong address instead of returning byte 0. It sends a start address with the high bits set. If those bits leak into the memory index, the returned bytes are wrong. It sends a non-read command whose address bits spell out 0x03, which exposes a design that keeps decoding after a bad command. It also raises chip select in the middle of a command, an address and a data byte. A design that keeps its bit counters across frames would misframe the following read, or leave SO driven.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } rd_state_e;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[g] <= RST_VAL;
        else         st_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[g] <= RST_VAL;
        else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int         ADDR_W = 12,
  parameter logic [7:0] RD_OP  = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_idle_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int CMD_LAST  = 7;
  localparam int ADDR_LAST = 15;

  rd_state_e         state_q;
  logic [3:0]        cnt_q;
  logic [ADDR_W-2:0] sh_q;
  logic [ADDR_W-1:0] sh_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              rd_q, rd_d1_q, so_q, oe_q;

  // address shifter keeps only ADDR_W bits: upper address bits fall off
  assign sh_nxt = {sh_q, si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_q    <= 1'b0;
      rd_d1_q <= 1'b0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      rd_q    <= 1'b0;
      rd_d1_q <= rd_q;
      if (rd_d1_q) data_q <= mem_rdata_i;
      if (cs_idle_i) begin
        state_q <= ST_CMD;
        cnt_q   <= '0;
        so_q    <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_CMD: if (sck_rise_i) begin
            sh_q  <= sh_nxt[ADDR_W-2:0];
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'(CMD_LAST)) begin
              cnt_q   <= '0;
              state_q <= (sh_nxt[7:0] == RD_OP) ? ST_ADDR : ST_SKIP;
            end
          end
          ST_ADDR: if (sck_rise_i) begin
            sh_q  <= sh_nxt[ADDR_W-2:0];
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'(ADDR_LAST)) begin
              cnt_q   <= '0;
              addr_q  <= sh_nxt;
              rd_q    <= 1'b1;
              state_q <= ST_DATA;
            end
          end
          ST_DATA: if (sck_fall_i) begin
            so_q  <= data_q[3'd7 - cnt_q[2:0]];
            oe_q  <= 1'b1;
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q[2:0] == 3'd7) begin
              cnt_q  <= '0;
              addr_q <= addr_q + 1'b1;  // natural wrap at array top
              rd_q   <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign so_o       = so_q;
  assign so_oe_o    = oe_q;
  assign mem_rd_o   = rd_q;
  assign mem_addr_o = addr_q;

  a_r2_oe_only_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> state_q == ST_DATA);
  a_r4_so_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall_i && !cs_idle_i) |=> $stable(so_o));
  a_r5_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  a_r7_skip_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> (!mem_rd_o && !so_oe_o));
  a_r8_cs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_idle_i |=> (!so_oe_o && state_q == ST_CMD));
endmodule

// File: rtl/spi_rd_seq.sv
module spi_rd_seq #(
  parameter int         ADDR_W      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] RD_OP       = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i
);
  logic [2:0] pin_s;
  logic       cs_s, sck_s, si_s, sck_prev_q;

  spi_rd_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i}),
    .q_o   (pin_s)
  );

  assign {cs_s, sck_s, si_s} = pin_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_prev_q <= 1'b0;
    else         sck_prev_q <= sck_s;

  spi_rd_ctrl #(
    .ADDR_W(ADDR_W),
    .RD_OP (RD_OP)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_idle_i  (cs_s),
    .sck_rise_i (sck_s & ~sck_prev_q),
    .sck_fall_i (~sck_s & sck_prev_q),
    .si_i       (si_s),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .mem_rdata_i(mem_rdata_i)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!so_oe_o && !mem_rd_o));
endmodule

// File: tb/tb_spi_rd_seq.sv
module tb_spi_rd_seq;
  localparam int AW   = 12;
  localparam int HALF = 8;

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] ad;
    logic [7:0]  nb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{op: 8'h03, ad: 16'h0010, nb: 8'd3},
    '{op: 8'h03, ad: 16'h0FFE, nb: 8'd4},
    '{op: 8'h03, ad: 16'hF123, nb: 8'd2},
    '{op: 8'h05, ad: 16'h0300, nb: 8'd3},
    '{op: 8'h03, ad: 16'h0800, nb: 8'd1},
    '{op: 8'h83, ad: 16'h0010, nb: 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_rd_seq #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_f(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic so_v, output logic oe_v);
    si = b;
    repeat (HALF) @(negedge clk);
    so_v = so;
    oe_v = so_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic end_frame();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] op, input logic [15:0] ad, input int nb);
    logic sv, ov, oe_any, oe_all;
    logic [7:0] byte_v;
    logic [AW-1:0] a;
    cs_n = 1'b0;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin sbit(op[i], sv, ov); oe_any |= ov; end
    for (int i = 15; i >= 0; i--) begin sbit(ad[i], sv, ov); oe_any |= ov; end
    chk("R2 oe during command/address", 32'(oe_any), 32'd0);
    a = ad[AW-1:0];
    for (int k = 0; k < nb; k++) begin
      oe_all = 1'b1; oe_any = 1'b0;
      for (int i = 7; i >= 0; i--) begin
        sbit(1'b0, sv, ov);
        byte_v[i] = sv; oe_all &= ov; oe_any |= ov;
      end
      if (op == 8'h03) begin
        chk("R3/R4/R5/R6 data byte", 32'(byte_v), 32'(mem_f(a)));
        chk("R4 oe in data", 32'(oe_all), 32'd1);
      end else begin
        chk("R7 oe after bad command", 32'(oe_any), 32'd0);
      end
      a = a + 1'b1;
    end
    end_frame();
  endtask

  initial begin
    logic sv, ov;
    logic [7:0] byte_v;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", 32'(so_oe), 32'd0);
    chk("R1 rd in reset", 32'(mem_rd), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset", 32'(so_oe), 32'd0);

    foreach (VECS[v]) run_frame(VECS[v].op, VECS[v].ad, int'(VECS[v].nb));

    // R8: abort inside command byte, then full read
    cs_n = 1'b0;
    for (int i = 0; i < 4; i++) sbit(1'b1, sv, ov);
    end_frame();
    run_frame(8'h03, 16'h0ABC, 2);

    // R8: abort inside address
    cs_n = 1'b0;
    for (int i = 7; i >= 0; i--) sbit(8'h03 >> i, sv, ov);
    for (int i = 0; i < 6; i++) sbit(1'b1, sv, ov);
    end_frame();
    chk("R8 oe after address abort", 32'(so_oe), 32'd0);
    run_frame(8'h03, 16'h0234, 2);

    // R8: abort inside data byte
    cs_n = 1'b0;
    for (int i = 7; i >= 0; i--) sbit(8'h03 >> i, sv, ov);
    for (int i = 15; i >= 0; i--) sbit(16'h0100 >> i, sv, ov);
    for (int i = 7; i >= 4; i--) begin sbit(1'b0, sv, ov); byte_v[i] = sv; end
    chk("R4 partial byte", 32'(byte_v[7:4]), 32'(mem_f(12'h100) >> 4));
    chk("R8 oe before abort", 32'(so_oe), 32'd1);
    end_frame();
    chk("R8 oe after data abort", 32'(so_oe), 32'd0);
    run_frame(8'h03, 16'h0FFF, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule